// File: doc/BRIEF.md
# Serial Receiver with Sticky Error Status

This block receives one asynchronous serial channel. A separate enable pulse, the oversampling tick, comes in at sixteen times the bit rate. The block finds the falling edge of a start bit and confirms it half a bit later. It then samples each following bit once, at its centre, and builds a character of seven or eight data bits, least significant bit first. If a parity bit is configured, the block checks it, and then it checks the first stop bit. The finished character goes into a single holding register, and an unread flag tells the host that the register has not yet been collected.

A three-bit sticky status word records a bad parity bit, a stop bit sampled low, and a character that arrived while the previous one was still unread. When a character completes, the block raises a one-cycle interrupt pulse. A clean character always raises the receive pulse. A character with any error raises either the receive pulse or a dedicated error pulse, and a routing input chooses which one. The host clears the status by strobing a status read and clears the unread flag by strobing a buffer read.

Top module: `serial_rx_core`

## Requirements
- R1: After synchronous reset, the received data is 0x00, all three status bits are 0, the unread flag is 0 and neither interrupt pulse is high.
- R2: A low level on the line starts a frame only if the line is still low when the block samples it eight ticks later. A shorter low pulse is discarded: no interrupt, no data change.
- R3: When `len8_i` is 1 a frame carries 8 data bits. When it is 0 it carries 7 data bits and bit 7 of the received data reads 0. Data bits arrive least significant bit first, each sampled once at its centre.
- R4: `par_mode_i` selects the parity bit: 00 none, 01 always zero, 10 odd (the data ones plus the parity bit give an odd count), 11 even. A mismatch sets status bit 2.
- R5: A first stop bit sampled low sets status bit 1. Exactly one stop bit is examined.
- R6: If a character completes while the unread flag is set and no buffer read happens in that cycle, status bit 0 is set and the new character replaces the old one.
- R7: Each completed character loads the data register, sets the unread flag and produces exactly one single-cycle interrupt pulse.
- R8: A character with no error pulses `irq_rx_o`. A character with any status bit raised pulses `irq_rx_o` when `err_to_rx_i` is 1, and pulses `irq_err_o` (and not `irq_rx_o`) when it is 0. The two pulses are never high together.
- R9: Status bits hold until `rd_stat_i` clears all three. `rd_buf_i` clears the unread flag. If a character completes in the same cycle as a read, the new set condition wins.
- R10: While `rx_en_i` is 0 the line is ignored and any frame in progress is dropped.
- R11: The receiver advances only in cycles where `tick_i` is high. With the tick held low, a frame on the line produces nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Oversampling enable, 16 per bit time |
| rxd_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Receive enable |
| par_mode_i | input | 2 | Parity selection |
| len8_i | input | 1 | 1: eight data bits, 0: seven |
| err_to_rx_i | input | 1 | Route errored characters to the receive interrupt |
| rd_buf_i | input | 1 | Buffer read strobe, clears the unread flag |
| rd_stat_i | input | 1 | Status read strobe, clears the status bits |
| rx_data_o | output | 8 | Last received character |
| err_stat_o | output | 3 | Bit 2 parity, bit 1 framing, bit 0 overrun |
| rx_full_o | output | 1 | Unread flag |
| irq_rx_o | output | 1 | Receive interrupt pulse |
| irq_err_o | output | 1 | Error interrupt pulse |

## Verification
The main sweep sends a spread of byte values, including all-zeros and all-ones, under every parity mode and both character lengths. The all-zeros and all-ones values separate the odd and even parity rules and expose a bit-ordering or bit-7 masking fault. Errored frames carrying a flipped parity bit or a low stop bit are sent with the routing input both set and clear, which tells apart which interrupt fires and which status bit is raised. Back-to-back frames without a read, a short start glitch, a disabled receiver and a stalled tick each check that the block does nothing beyond what the requirements allow.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int CHAR_W = 8;
    localparam int IDX_W  = $clog2(CHAR_W);
    localparam int STAT_W = 3;

    // status bit positions
    localparam int STAT_PAR  = 2;
    localparam int STAT_FRM  = 1;
    localparam int STAT_OVR  = 0;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic      len8;
        par_mode_e par;
    } rx_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [CHAR_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_result_t;

    // acc: xor of the received data bits, pbit: received parity bit
    function automatic logic parity_mismatch(par_mode_e m, logic acc, logic pbit);
        logic bad;
        case (m)
            PAR_ZERO: bad = pbit;
            PAR_ODD:  bad = ~(acc ^ pbit);
            PAR_EVEN: bad = acc ^ pbit;
            default:  bad = 1'b0;
        endcase
        return bad;
    endfunction

    function automatic logic [IDX_W-1:0] last_bit_index(logic len8);
        return len8 ? IDX_W'(CHAR_W - 1) : IDX_W'(CHAR_W - 2);
    endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) pipe_q <= 1'b1;
                else     pipe_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) pipe_q <= '1;
                else     pipe_q <= {pipe_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
    import serial_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    input  logic       enable,
    input  rx_cfg_t    cfg_in,
    output rx_result_t result
);
    localparam int CNT_W    = $clog2(OSR);
    localparam int MID_CNT  = OSR / 2 - 1;
    localparam int LAST_CNT = OSR - 1;

    rx_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CHAR_W-1:0] shift_q;
    logic              acc_q;
    logic              pbit_q;
    rx_cfg_t           cfg_q;

    logic at_mid, at_end;
    assign at_mid = (cnt_q == CNT_W'(MID_CNT));
    assign at_end = (cnt_q == CNT_W'(LAST_CNT));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            acc_q   <= 1'b0;
            pbit_q  <= 1'b0;
            cfg_q   <= '0;
            result  <= '0;
        end else begin
            result.valid <= 1'b0;
            if (!enable) begin
                state_q <= RX_IDLE;
                cnt_q   <= '0;
            end else if (tick) begin
                case (state_q)
                    RX_IDLE: begin
                        cnt_q <= '0;
                        if (!line) state_q <= RX_START;
                    end
                    RX_START: begin
                        if (at_mid) begin
                            cnt_q <= '0;
                            if (!line) begin
                                state_q <= RX_DATA;
                                cfg_q   <= cfg_in;
                                idx_q   <= '0;
                                shift_q <= '0;
                                acc_q   <= 1'b0;
                                pbit_q  <= 1'b0;
                            end else begin
                                state_q <= RX_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (at_end) begin
                            cnt_q          <= '0;
                            shift_q[idx_q] <= line;
                            acc_q          <= acc_q ^ line;
                            if (idx_q == last_bit_index(cfg_q.len8)) begin
                                state_q <= (cfg_q.par == PAR_NONE) ? RX_STOP : RX_PARITY;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_PARITY: begin
                        if (at_end) begin
                            cnt_q   <= '0;
                            pbit_q  <= line;
                            state_q <= RX_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (at_end) begin
                            cnt_q        <= '0;
                            state_q      <= RX_IDLE;
                            result.valid <= 1'b1;
                            result.data  <= shift_q;
                            result.perr  <= parity_mismatch(cfg_q.par, acc_q, pbit_q);
                            result.ferr  <= ~line;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/serial_rx_host.sv
module serial_rx_host
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rx_result_t        result,
    input  logic              rd_buf,
    input  logic              rd_stat,
    input  logic              err_to_rx,
    output logic [CHAR_W-1:0] data_q,
    output logic [STAT_W-1:0] stat_q,
    output logic              full_q,
    output logic              irq_rx,
    output logic              irq_err
);
    logic [STAT_W-1:0] new_err;
    logic [STAT_W-1:0] stat_base;

    always_comb begin
        new_err           = '0;
        new_err[STAT_PAR] = result.perr;
        new_err[STAT_FRM] = result.ferr;
        new_err[STAT_OVR] = full_q & ~rd_buf;
        stat_base         = rd_stat ? '0 : stat_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            stat_q  <= '0;
            full_q  <= 1'b0;
            irq_rx  <= 1'b0;
            irq_err <= 1'b0;
        end else begin
            irq_rx  <= 1'b0;
            irq_err <= 1'b0;
            if (result.valid) begin
                data_q <= result.data;
                full_q <= 1'b1;
                stat_q <= stat_base | new_err;
                if ((new_err == '0) || err_to_rx) irq_rx  <= 1'b1;
                else                              irq_err <= 1'b1;
            end else begin
                stat_q <= stat_base;
                if (rd_buf) full_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic                 rxd_i,
    input  logic                 rx_en_i,
    input  logic [1:0]           par_mode_i,
    input  logic                 len8_i,
    input  logic                 err_to_rx_i,
    input  logic                 rd_buf_i,
    input  logic                 rd_stat_i,
    output logic [CHAR_W-1:0]    rx_data_o,
    output logic [STAT_W-1:0]    err_stat_o,
    output logic                 rx_full_o,
    output logic                 irq_rx_o,
    output logic                 irq_err_o
);
    logic       line_s;
    rx_cfg_t    cfg;
    rx_result_t res;

    assign cfg.len8 = len8_i;
    assign cfg.par  = par_mode_e'(par_mode_i);

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd_i),
        .dout (line_s)
    );

    serial_rx_frame #(.OSR(OSR)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_i),
        .line   (line_s),
        .enable (rx_en_i),
        .cfg_in (cfg),
        .result (res)
    );

    serial_rx_host u_host (
        .clk       (clk),
        .rst       (rst),
        .result    (res),
        .rd_buf    (rd_buf_i),
        .rd_stat   (rd_stat_i),
        .err_to_rx (err_to_rx_i),
        .data_q    (rx_data_o),
        .stat_q    (err_stat_o),
        .full_q    (rx_full_o),
        .irq_rx    (irq_rx_o),
        .irq_err   (irq_err_o)
    );
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_en_i,
    input logic       err_to_rx_i,
    input logic       rd_buf_i,
    input logic       rd_stat_i,
    input logic [7:0] rx_data_o,
    input logic [2:0] err_stat_o,
    input logic       rx_full_o,
    input logic       irq_rx_o,
    input logic       irq_err_o
);
    logic any_irq;
    assign any_irq = irq_rx_o | irq_err_o;

    // R8
    irq_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(irq_rx_o && irq_err_o));

    // R8
    err_irq_has_status_chk: assert property (@(posedge clk) disable iff (rst)
        irq_err_o |-> (err_stat_o != 3'b000) && !$past(err_to_rx_i));

    // R7
    irq_sets_full_chk: assert property (@(posedge clk) disable iff (rst)
        any_irq |-> rx_full_o);

    // R7
    data_only_on_irq_chk: assert property (@(posedge clk) disable iff (rst)
        !any_irq |-> $stable(rx_data_o));

    // R9
    stat_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rd_stat_i) && !any_irq |-> err_stat_o == 3'b000);

    // R9
    buf_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rd_buf_i) && !any_irq |-> !rx_full_o);

    // R9
    stat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_stat_i) |-> (err_stat_o & $past(err_stat_o)) == $past(err_stat_o));

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_en_i && !$past(rx_en_i) && !$past(rx_en_i, 2) |-> !any_irq);
endmodule

bind serial_rx_core serial_rx_core_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_en_i     (rx_en_i),
    .err_to_rx_i (err_to_rx_i),
    .rd_buf_i    (rd_buf_i),
    .rd_stat_i   (rd_stat_i),
    .rx_data_o   (rx_data_o),
    .err_stat_o  (err_stat_o),
    .rx_full_o   (rx_full_o),
    .irq_rx_o    (irq_rx_o),
    .irq_err_o   (irq_err_o)
);

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 2;
    localparam int OSR        = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b1;
    logic [1:0] par_mode = 2'b00;
    logic       len8 = 1'b1;
    logic       err_to_rx = 1'b1;
    logic       rd_buf = 1'b0;
    logic       rd_stat = 1'b0;
    logic [7:0] rx_data;
    logic [2:0] err_stat;
    logic       rx_full;
    logic       irq_rx;
    logic       irq_err;

    int  n_checks = 0;
    int  n_errors = 0;
    int  n_rx = 0;
    int  n_err = 0;
    int  tcnt = 0;
    bit  tick_en = 1'b1;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_rx_core u_dut (
        .clk(clk), .rst(rst), .tick_i(tick), .rxd_i(rxd), .rx_en_i(rx_en),
        .par_mode_i(par_mode), .len8_i(len8), .err_to_rx_i(err_to_rx),
        .rd_buf_i(rd_buf), .rd_stat_i(rd_stat), .rx_data_o(rx_data),
        .err_stat_o(err_stat), .rx_full_o(rx_full), .irq_rx_o(irq_rx),
        .irq_err_o(irq_err)
    );

    // tick generator and interrupt counters, away from the active edge
    always @(negedge clk) begin
        if (irq_rx)  n_rx++;
        if (irq_err) n_err++;
        tcnt = (tcnt + 1) % TDIV;
        tick = tick_en && (tcnt == 0);
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic b, input int ticks);
        rxd = b;
        repeat (ticks * TDIV) @(negedge clk);
    endtask

    task automatic host_clear();
        @(negedge clk);
        rd_buf = 1'b1; rd_stat = 1'b1;
        @(negedge clk);
        rd_buf = 1'b0; rd_stat = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        int  nb;
        logic p;
        logic [7:0] dm;
        nb = len8 ? 8 : 7;
        dm = len8 ? d : {1'b0, d[6:0]};
        case (par_mode)
            2'b01:   p = 1'b0;
            2'b10:   p = ~(^dm);
            default: p = ^dm;
        endcase
        @(negedge clk);
        hold_bit(1'b0, OSR);
        for (int i = 0; i < nb; i++) hold_bit(d[i], OSR);
        if (par_mode != 2'b00) hold_bit(p ^ bad_par, OSR);
        if (bad_stop) begin
            hold_bit(1'b0, 11);
            hold_bit(1'b1, OSR + 5);
        end else begin
            hold_bit(1'b1, OSR);
        end
        hold_bit(1'b1, OSR);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int rx0, er0;
        logic [7:0] d, exp_d;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 data", rx_data, 0);
        check("R1 status", err_stat, 0);
        check("R1 full", rx_full, 0);
        check("R1 irq", irq_rx | irq_err, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // main sweep: both lengths, all parity modes
        for (int l = 0; l < 2; l++) begin
            for (int pm = 0; pm < 4; pm++) begin
                for (int k = 0; k < 12; k++) begin
                    len8 = l[0];
                    par_mode = pm[1:0];
                    d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(k * 53 + 7);
                    exp_d = len8 ? d : {1'b0, d[6:0]};
                    host_clear();
                    rx0 = n_rx; er0 = n_err;
                    send(d, 1'b0, 1'b0);
                    check("R3 R11 data", rx_data, exp_d);
                    check("R4 clean status", err_stat, 0);
                    check("R7 one rx pulse", n_rx - rx0, 1);
                    check("R8 no err pulse", n_err - er0, 0);
                    check("R7 full", rx_full, 1);
                end
            end
        end

        // R4 R8 parity error routed to error interrupt
        len8 = 1'b1; par_mode = 2'b10; err_to_rx = 1'b0;
        host_clear(); rx0 = n_rx; er0 = n_err;
        send(8'h5A, 1'b1, 1'b0);
        check("R4 parity status", err_stat, 3'b100);
        check("R8 err pulse", n_err - er0, 1);
        check("R8 no rx pulse", n_rx - rx0, 0);
        check("R4 data kept", rx_data, 8'h5A);

        // R4 R8 zero-parity error routed to receive interrupt
        par_mode = 2'b01; err_to_rx = 1'b1;
        host_clear(); rx0 = n_rx; er0 = n_err;
        send(8'h33, 1'b1, 1'b0);
        check("R4 zero parity status", err_stat, 3'b100);
        check("R8 rx pulse on error", n_rx - rx0, 1);
        check("R8 no err pulse", n_err - er0, 0);

        // R5 framing error, 7-bit, no parity
        len8 = 1'b0; par_mode = 2'b00; err_to_rx = 1'b0;
        host_clear(); rx0 = n_rx; er0 = n_err;
        send(8'h41, 1'b0, 1'b1);
        check("R5 framing status", err_stat, 3'b010);
        check("R5 err pulse", n_err - er0, 1);
        check("R5 data", rx_data, 8'h41);

        // R6 overrun, then R9 clearing
        len8 = 1'b1; err_to_rx = 1'b1;
        host_clear(); rx0 = n_rx; er0 = n_err;
        send(8'hA5, 1'b0, 1'b0);
        send(8'h3C, 1'b0, 1'b0);
        check("R6 overrun status", err_stat, 3'b001);
        check("R6 data overwritten", rx_data, 8'h3C);
        check("R6 pulses", n_rx - rx0, 2);
        @(negedge clk); rd_stat = 1'b1; @(negedge clk); rd_stat = 1'b0;
        @(negedge clk);
        check("R9 status cleared", err_stat, 0);
        check("R9 full kept", rx_full, 1);
        @(negedge clk); rd_buf = 1'b1; @(negedge clk); rd_buf = 1'b0;
        @(negedge clk);
        check("R9 full cleared", rx_full, 0);

        // R2 short start glitch
        rx0 = n_rx; er0 = n_err;
        @(negedge clk);
        hold_bit(1'b0, 4);
        hold_bit(1'b1, 3 * OSR);
        check("R2 no pulse", (n_rx - rx0) + (n_err - er0), 0);
        check("R2 data unchanged", rx_data, 8'h3C);
        check("R2 full", rx_full, 0);

        // R10 receiver disabled
        rx_en = 1'b0; rx0 = n_rx; er0 = n_err;
        send(8'h96, 1'b0, 1'b0);
        check("R10 no pulse", (n_rx - rx0) + (n_err - er0), 0);
        check("R10 data unchanged", rx_data, 8'h3C);
        check("R10 full", rx_full, 0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // R11 tick held low
        tick_en = 1'b0; rx0 = n_rx; er0 = n_err;
        send(8'h69, 1'b0, 1'b0);
        check("R11 no pulse", (n_rx - rx0) + (n_err - er0), 0);
        check("R11 data unchanged", rx_data, 8'h3C);
        tick_en = 1'b1;
        repeat (4 * OSR * TDIV) @(negedge clk);
        check("R11 still idle", rx_full, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule